// File: doc/BRIEF.md
# Scatter-Gather DMA Channel Sequencer

This block is one DMA channel. It copies a run of equal-width elements between a fixed device address and a memory address that steps forward by one element after each copy. The channel starts on a one-cycle kick and runs in one of two ways. In one-shot mode it takes its device address, memory address, size word and link word straight from the four loaded register inputs and performs that single transfer. In scatter-gather mode it uses only the loaded link register. It then walks a chain of four-word descriptors held in memory, fetching each descriptor before it moves that descriptor's data.

All traffic goes through one memory port. The port has a request/grant handshake and returns read data in the grant cycle, so descriptor fetches, element reads and element writes all share it. The channel reports what it is doing on a 2-bit activity code. It raises a one-cycle interrupt when a descriptor that asks for one finishes. It has a sticky error flag for descriptors it refuses to run. A mode field of zero aborts the channel at any time.

Top module: `sgdma_channel`

## Requirements
- R1: After reset the activity code is 0, the interrupt and error outputs are low and no memory request is raised.
- R2: On a kick with mode 2 (one-shot; 0 is off, 1 is scatter-gather), the channel moves the number of elements given in size bits 10:0. Every device access uses the same device address, and the memory address advances by the element width after each element.
- R3: Direction input 1 reads each element at the memory address and writes it to the device address. Direction 0 reads it from the device address and writes it to the memory address. Data is right-aligned on the port.
- R4: Size bits 13:12 select the element width: 3 is 1 byte, 2 is 2 bytes, 0 is 4 bytes. The port size output is 0, 1 or 2 for 1, 2 or 4 bytes and is never 3.
- R5: On a kick with mode 1, the channel reads four 32-bit words at the link address with its low four bits forced to zero. The words, in order, are device address, memory address, size and link. While link bit 1 of the fetched word is 1, the channel follows to the next descriptor; when it is 0, the channel stops.
- R6: When a descriptor's last element is written, the interrupt output pulses for exactly one cycle if link bit 0 is 1, and stays low otherwise.
- R7: A descriptor is refused if its count is 0, its width code is 1, or its count exceeds 0x3FF at 1- or 2-byte width. A refused descriptor moves no data, the channel returns to idle, the error output goes high and the interrupt pulses. The error output stays high until the next accepted kick.
- R8: Mode 0 while the channel is busy returns it to idle on the next clock edge with no interrupt. This holds even when that edge also grants the last element write.
- R9: The activity code is 1 while descriptor words are read, 2 in the decode cycle before data moves, 3 during element reads and writes, and 0 when idle.
- R10: In one-shot mode the link bits only choose the interrupt; the channel never fetches a descriptor, even when link bit 1 is set.
- R11: A kick that arrives while the channel is busy is ignored, and register changes made during a transfer do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 off/abort, 1 scatter-gather, 2 one-shot |
| cfg_dir | input | 1 | 1 memory to device, 0 device to memory |
| cfg_kick | input | 1 | One-cycle start request |
| reg_dev | input | W | Device address (one-shot) |
| reg_mem | input | W | Memory start address (one-shot) |
| reg_size | input | W | Width code and element count (one-shot) |
| reg_link | input | W | Link word: control bits, or chain head in scatter-gather |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | 1 write, 0 read |
| mem_addr | output | W | Access address |
| mem_size | output | 2 | Log2 of access bytes |
| mem_wdata | output | W | Write data, right-aligned |
| mem_gnt | input | 1 | Grant; read data valid in this cycle |
| mem_rdata | input | W | Read data, right-aligned |
| act_state | output | 2 | Activity code |
| irq | output | 1 | Completion interrupt pulse |
| err | output | 1 | Sticky refused-descriptor flag |

## Verification
Two events can land on the same clock edge: the grant of a descriptor's last element write, which would complete the descriptor and raise the interrupt, and an abort through mode 0. The memory model in the bench arms a trigger that drops the mode in the very cycle it grants that final device write. The bench then checks three things: the write took place, the interrupt never pulsed, and the channel sat idle with the error flag low. A second case aborts in the middle of a transfer and checks that the channel is idle one edge later.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_FETCH,
      SQ_CHECK,
      SQ_READ,
      SQ_WRITE
   } seq_t;

   localparam logic [1:0] MODE_OFF = 2'd0;
   localparam logic [1:0] MODE_SG  = 2'd1;
   localparam logic [1:0] MODE_ONE = 2'd2;

   localparam logic [1:0] ACT_IDLE = 2'd0;
   localparam logic [1:0] ACT_DESC = 2'd1;
   localparam logic [1:0] ACT_WAIT = 2'd2;
   localparam logic [1:0] ACT_XFER = 2'd3;

   function automatic logic [1:0] act_of(seq_t s);
      case (s)
         SQ_FETCH:          act_of = ACT_DESC;
         SQ_CHECK:          act_of = ACT_WAIT;
         SQ_READ, SQ_WRITE: act_of = ACT_XFER;
         default:           act_of = ACT_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/sgdma_desc_check.sv
module sgdma_desc_check #(
   parameter int W           = 32,
   parameter int CNT_W       = 11,
   parameter bit LIMIT_CHECK = 1'b1
) (
   input  logic [W-1:0]     size_word,
   output logic             ok,
   output logic [1:0]       lg_bytes,
   output logic [CNT_W-1:0] count
);
   localparam int WSEL_LO   = 12;
   localparam int SMALL_LIM = 1023;

   logic       code_bad;
   logic       over_lim;
   logic [1:0] wcode;

   assign wcode = size_word[WSEL_LO+1:WSEL_LO];
   assign count = size_word[CNT_W-1:0];

   always_comb begin
      code_bad = 1'b0;
      case (wcode)
         2'd3:    lg_bytes = 2'd0;
         2'd2:    lg_bytes = 2'd1;
         2'd0:    lg_bytes = 2'd2;
         default: begin
            lg_bytes = 2'd0;
            code_bad = 1'b1;
         end
      endcase
   end

   generate
      if (CNT_W < 10 || CNT_W > 12) begin : g_bad_cnt
         $error("sgdma_desc_check: CNT_W must be 10..12");
      end
      if (W < 16) begin : g_bad_w
         $error("sgdma_desc_check: W must be at least 16");
      end
      if (LIMIT_CHECK) begin : g_limit
         assign over_lim = (lg_bytes != 2'd2) && (count > CNT_W'(SMALL_LIM));
      end else begin : g_nolimit
         assign over_lim = 1'b0;
      end
      if (CNT_W < 12) begin : g_pad
         wire unused_mid = ^size_word[11:CNT_W];
      end
   endgenerate

   wire unused_hi = ^size_word[W-1:WSEL_LO+2];

   assign ok = !code_bad && !over_lim && (count != '0);

endmodule

// File: rtl/sgdma_port_mux.sv
module sgdma_port_mux
   import sgdma_pkg::*;
#(
   parameter int W = 32
) (
   input  seq_t         seq,
   input  logic [W-1:0] ptr,
   input  logic [1:0]   widx,
   input  logic [W-1:0] src,
   input  logic [W-1:0] dst,
   input  logic [1:0]   lg,
   input  logic [W-1:0] dbuf,
   output logic         req,
   output logic         wr,
   output logic [W-1:0] addr,
   output logic [1:0]   size,
   output logic [W-1:0] wdata
);
   always_comb begin
      req   = 1'b0;
      wr    = 1'b0;
      addr  = '0;
      size  = 2'd0;
      wdata = '0;
      case (seq)
         SQ_FETCH: begin
            req  = 1'b1;
            addr = ptr + W'({widx, 2'b00});
            size = 2'd2;
         end
         SQ_READ: begin
            req  = 1'b1;
            addr = src;
            size = lg;
         end
         SQ_WRITE: begin
            req   = 1'b1;
            wr    = 1'b1;
            addr  = dst;
            size  = lg;
            wdata = dbuf;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sgdma_channel.sv
module sgdma_channel
   import sgdma_pkg::*;
#(
   parameter int W           = 32,
   parameter int CNT_W       = 11,
   parameter int ALIGN_LG    = 4,
   parameter bit LIMIT_CHECK = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   cfg_mode,
   input  logic         cfg_dir,
   input  logic         cfg_kick,
   input  logic [W-1:0] reg_dev,
   input  logic [W-1:0] reg_mem,
   input  logic [W-1:0] reg_size,
   input  logic [W-1:0] reg_link,
   output logic         mem_req,
   output logic         mem_wr,
   output logic [W-1:0] mem_addr,
   output logic [1:0]   mem_size,
   output logic [W-1:0] mem_wdata,
   input  logic         mem_gnt,
   input  logic [W-1:0] mem_rdata,
   output logic [1:0]   act_state,
   output logic         irq,
   output logic         err
);
   localparam int LINK_FOLLOW = 1;
   localparam int LINK_IRQ    = 0;

   generate
      if (ALIGN_LG < 4 || ALIGN_LG >= W) begin : g_bad_align
         $error("sgdma_channel: ALIGN_LG must cover a four-word descriptor");
      end
   endgenerate

   seq_t             seq;
   logic [1:0]       widx;
   logic [W-1:0]     ptr, w_dev, w_mem, w_size, w_link, dbuf;
   logic [CNT_W-1:0] cnt;
   logic             dir_q, one_q, irq_q, err_q;

   logic             d_ok;
   logic [1:0]       d_lg;
   logic [CNT_W-1:0] d_count;
   logic [W-1:0]     src, dst, step;

   function automatic logic [W-1:0] align_ptr(logic [W-1:0] v);
      return {v[W-1:ALIGN_LG], {ALIGN_LG{1'b0}}};
   endfunction

   wire unused_link = ^{reg_link[ALIGN_LG-1:0], w_link[ALIGN_LG-1:2]};

   sgdma_desc_check #(.W(W), .CNT_W(CNT_W), .LIMIT_CHECK(LIMIT_CHECK)) i_check (
      .size_word (w_size),
      .ok        (d_ok),
      .lg_bytes  (d_lg),
      .count     (d_count)
   );

   assign src  = dir_q ? w_mem : w_dev;
   assign dst  = dir_q ? w_dev : w_mem;
   assign step = W'(1) << d_lg;

   sgdma_port_mux #(.W(W)) i_mux (
      .seq   (seq),
      .ptr   (ptr),
      .widx  (widx),
      .src   (src),
      .dst   (dst),
      .lg    (d_lg),
      .dbuf  (dbuf),
      .req   (mem_req),
      .wr    (mem_wr),
      .addr  (mem_addr),
      .size  (mem_size),
      .wdata (mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq    <= SQ_IDLE;
         widx   <= 2'd0;
         ptr    <= '0;
         w_dev  <= '0;
         w_mem  <= '0;
         w_size <= '0;
         w_link <= '0;
         dbuf   <= '0;
         cnt    <= '0;
         dir_q  <= 1'b0;
         one_q  <= 1'b0;
         irq_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (seq != SQ_IDLE && cfg_mode == MODE_OFF) begin
            seq <= SQ_IDLE;
         end else begin
            case (seq)
               SQ_IDLE: begin
                  if (cfg_kick && cfg_mode == MODE_SG) begin
                     ptr   <= align_ptr(reg_link);
                     widx  <= 2'd0;
                     dir_q <= cfg_dir;
                     one_q <= 1'b0;
                     err_q <= 1'b0;
                     seq   <= SQ_FETCH;
                  end else if (cfg_kick && cfg_mode == MODE_ONE) begin
                     w_dev  <= reg_dev;
                     w_mem  <= reg_mem;
                     w_size <= reg_size;
                     w_link <= reg_link;
                     dir_q  <= cfg_dir;
                     one_q  <= 1'b1;
                     err_q  <= 1'b0;
                     seq    <= SQ_CHECK;
                  end
               end
               SQ_FETCH: begin
                  if (mem_gnt) begin
                     case (widx)
                        2'd0:    w_dev  <= mem_rdata;
                        2'd1:    w_mem  <= mem_rdata;
                        2'd2:    w_size <= mem_rdata;
                        default: w_link <= mem_rdata;
                     endcase
                     widx <= widx + 2'd1;
                     if (widx == 2'd3) seq <= SQ_CHECK;
                  end
               end
               SQ_CHECK: begin
                  if (!d_ok) begin
                     err_q <= 1'b1;
                     irq_q <= 1'b1;
                     seq   <= SQ_IDLE;
                  end else begin
                     cnt <= d_count;
                     seq <= SQ_READ;
                  end
               end
               SQ_READ: begin
                  if (mem_gnt) begin
                     dbuf <= mem_rdata;
                     seq  <= SQ_WRITE;
                  end
               end
               SQ_WRITE: begin
                  if (mem_gnt) begin
                     w_mem <= w_mem + step;
                     cnt   <= cnt - CNT_W'(1);
                     if (cnt == CNT_W'(1)) begin
                        irq_q <= w_link[LINK_IRQ];
                        if (!one_q && w_link[LINK_FOLLOW]) begin
                           ptr  <= align_ptr(w_link);
                           widx <= 2'd0;
                           seq  <= SQ_FETCH;
                        end else begin
                           seq <= SQ_IDLE;
                        end
                     end else begin
                        seq <= SQ_READ;
                     end
                  end
               end
               default: seq <= SQ_IDLE;
            endcase
         end
      end
   end

   assign act_state = act_of(seq);
   assign irq       = irq_q;
   assign err       = err_q;

endmodule

// File: rtl/sgdma_checker.sv
module sgdma_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_mode,
   input logic [1:0] act_state,
   input logic       irq,
   input logic       err,
   input logic       mem_req,
   input logic       mem_wr,
   input logic [1:0] mem_addr_lo,
   input logic [1:0] mem_size
);
   a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      act_state == 2'd0 |-> !mem_req);

   a_r4_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_size != 2'd3);

   a_r5_fetch_word_read: assert property (@(posedge clk) disable iff (!rst_n)
      (act_state == 2'd1 && mem_req) |-> (!mem_wr && mem_size == 2'd2 && mem_addr_lo == 2'd0));

   a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   a_r7_err_enters_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (act_state == 2'd0 && irq));

   a_r8_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd0 && act_state != 2'd0) |=> (act_state == 2'd0 && !irq));

   a_r9_wait_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      act_state == 2'd2 |-> !mem_req);
endmodule

bind sgdma_channel sgdma_checker i_sgdma_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_mode    (cfg_mode),
   .act_state   (act_state),
   .irq         (irq),
   .err         (err),
   .mem_req     (mem_req),
   .mem_wr      (mem_wr),
   .mem_addr_lo (mem_addr[1:0]),
   .mem_size    (mem_size)
);

// File: tb/test_sgdma_channel.sv
module test_sgdma_channel;
   localparam int W = 32;
   localparam logic [31:0] DEV_A  = 32'h0000_0F40;
   localparam logic [31:0] DEV_S0 = 32'h1234_5600;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   cfg_mode = 2'd0;
   logic         cfg_dir = 1'b0;
   logic         cfg_kick = 1'b0;
   logic [W-1:0] reg_dev = '0, reg_mem = '0, reg_size = '0, reg_link = '0;
   logic         mem_req, mem_wr;
   logic [W-1:0] mem_addr, mem_wdata;
   logic [1:0]   mem_size;
   logic         mem_gnt = 1'b0;
   logic [W-1:0] mem_rdata = '0;
   logic [1:0]   act_state;
   logic         irq, err;

   sgdma_channel i_sgdma_channel (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_dir(cfg_dir), .cfg_kick(cfg_kick),
      .reg_dev(reg_dev), .reg_mem(reg_mem), .reg_size(reg_size), .reg_link(reg_link),
      .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .act_state(act_state), .irq(irq), .err(err)
   );

   initial forever #5 clk = ~clk;

   int total = 0, bad = 0;
   bit finished = 1'b0;
   logic [7:0]  mem [0:4095];
   logic [31:0] dev_log [0:2047];
   int          dev_n = 0, irq_cnt = 0, act_bad = 0, devaddr_bad = 0, desc_rd = 0;
   logic [31:0] dev_src = DEV_S0;
   bit          seen_wait = 1'b0;
   bit          abort_arm = 1'b0;
   int          abort_idx = 0;

   function automatic logic [7:0] pat(int a);
      return 8'((a * 29 + 7) & 255);
   endfunction

   function automatic logic [31:0] exp_elem(int a, int nb);
      logic [31:0] v = '0;
      for (int i = 0; i < nb; i++) v |= 32'(pat(a + i)) << (8 * i);
      return v;
   endfunction

   function automatic logic [31:0] peek(int a, int nb);
      logic [31:0] v = '0;
      for (int i = 0; i < nb; i++) v |= 32'(mem[(a + i) & 4095]) << (8 * i);
      return v;
   endfunction

   function automatic logic [31:0] wmask(int nb);
      return (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 32'd1);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put32(int a, logic [31:0] v);
      for (int i = 0; i < 4; i++) mem[a + i] = v[8*i +: 8];
   endtask

   // memory and device model: grant one negedge after a request is seen
   initial forever begin
      @(negedge clk);
      if (irq) irq_cnt++;
      if (act_state == 2'd2) seen_wait = 1'b1;
      if (mem_req && !mem_gnt) begin
         automatic int a  = int'(mem_addr[11:0]);
         automatic int nb = 1 << mem_size;
         automatic bit isdev = (a >= 12'hF00);
         if (isdev && mem_addr != DEV_A) devaddr_bad++;
         if (!mem_wr && !isdev && a < 'h200) begin
            desc_rd++;
            if (act_state != 2'd1) act_bad++;
         end else if (act_state != 2'd3) act_bad++;
         if (!mem_wr) begin
            if (isdev) begin
               mem_rdata = dev_src & wmask(nb);
               dev_src   = dev_src + 1;
            end else mem_rdata = peek(a, nb);
         end else begin
            if (isdev) begin
               if (abort_arm && dev_n == abort_idx) begin
                  cfg_mode  = 2'd0;
                  abort_arm = 1'b0;
               end
               dev_log[dev_n] = mem_wdata & wmask(nb);
               dev_n++;
            end else
               for (int i = 0; i < nb; i++) mem[(a + i) & 4095] = mem_wdata[8*i +: 8];
         end
         mem_gnt = 1'b1;
      end else mem_gnt = 1'b0;
   end

   task automatic reset_run();
      dev_n = 0; irq_cnt = 0; act_bad = 0; devaddr_bad = 0; desc_rd = 0;
      dev_src = DEV_S0;
      for (int a = 'h600; a < 'h700; a++) mem[a] = 8'h00;
   endtask

   task automatic kick();
      @(negedge clk) cfg_kick = 1'b1;
      @(negedge clk) cfg_kick = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (act_state != 2'd0 && n < 20000) begin
         @(negedge clk);
         n++;
      end
      @(negedge clk);
   endtask

   task automatic one_shot(int dir, logic [1:0] wcode, int count, logic [31:0] link);
      cfg_mode = 2'd2;
      cfg_dir  = dir[0];
      reg_dev  = DEV_A;
      reg_mem  = dir ? 32'h200 : 32'h600;
      reg_size = (32'(wcode) << 12) | 32'(count);
      reg_link = link;
      kick();
      wait_idle();
   endtask

   initial begin
      for (int a = 0; a < 4096; a++) mem[a] = pat(a);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 act", 32'(act_state), 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 err", 32'(err), 0);
      chk("R1 req", 32'(mem_req), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R3 R4 R6: sweep width x direction x count
      for (int wi = 0; wi < 3; wi++) begin
         for (int dir = 0; dir < 2; dir++) begin
            for (int count = 1; count <= 3; count++) begin
               automatic int nb = (wi == 0) ? 1 : (wi == 1) ? 2 : 4;
               automatic logic [1:0] wc = (wi == 0) ? 2'd3 : (wi == 1) ? 2'd2 : 2'd0;
               reset_run();
               one_shot(dir, wc, count, (count == 2) ? 32'h1 : 32'h0);
               if (dir == 1) begin
                  chk("R3 dev count", 32'(dev_n), 32'(count));
                  for (int k = 0; k < count; k++)
                     chk("R2 mem-to-dev data", dev_log[k], exp_elem('h200 + k * nb, nb));
               end else begin
                  for (int k = 0; k < count; k++)
                     chk("R3 dev-to-mem data", peek('h600 + k * nb, nb), (DEV_S0 + 32'(k)) & wmask(nb));
                  chk("R2 stop after count", 32'(mem['h600 + count * nb]), 0);
               end
               chk("R6 irq count", 32'(irq_cnt), (count == 2) ? 1 : 0);
               chk("R4 no err", 32'(err), 0);
               chk("R9 act code", 32'(act_bad), 0);
               chk("R2 device addr fixed", 32'(devaddr_bad), 0);
            end
         end
      end
      chk("R9 wait seen", 32'(seen_wait), 1);

      // R7 refused descriptors
      reset_run();
      one_shot(1, 2'd3, 0, 32'h0);
      chk("R7 zero count err", 32'(err), 1);
      chk("R7 zero count irq", 32'(irq_cnt), 1);
      chk("R7 zero count no data", 32'(dev_n), 0);
      repeat (5) @(negedge clk);
      chk("R7 err sticky", 32'(err), 1);
      reset_run();
      one_shot(1, 2'd1, 2, 32'h0);
      chk("R7 reserved width err", 32'(err), 1);
      chk("R7 reserved width no data", 32'(dev_n), 0);
      reset_run();
      one_shot(1, 2'd2, 'h400, 32'h0);
      chk("R7 over limit err", 32'(err), 1);
      chk("R7 over limit irq", 32'(irq_cnt), 1);
      reset_run();
      one_shot(1, 2'd3, 'h3FF, 32'h0);
      chk("R7 limit accepted err clear", 32'(err), 0);
      chk("R7 limit count", 32'(dev_n), 'h3FF);
      chk("R7 limit last", dev_log['h3FE], exp_elem('h200 + 'h3FE, 1));

      // R10 one-shot ignores follow
      reset_run();
      one_shot(1, 2'd0, 2, 32'h183);
      chk("R10 no fetch", 32'(desc_rd), 0);
      chk("R10 count", 32'(dev_n), 2);
      chk("R10 irq", 32'(irq_cnt), 1);

      // R5 R6 scatter-gather chain
      put32('h100, DEV_A); put32('h104, 32'h300); put32('h108, (32'd3 << 12) | 4); put32('h10C, 32'h142);
      put32('h140, DEV_A); put32('h144, 32'h340); put32('h148, (32'd0 << 12) | 2); put32('h14C, 32'h183);
      put32('h180, DEV_A); put32('h184, 32'h360); put32('h188, (32'd2 << 12) | 3); put32('h18C, 32'h001);
      reset_run();
      cfg_mode = 2'd1; cfg_dir = 1'b1; reg_link = 32'h105;
      kick();
      wait_idle();
      chk("R5 chain count", 32'(dev_n), 9);
      for (int k = 0; k < 4; k++) chk("R5 desc A data", dev_log[k], exp_elem('h300 + k, 1));
      for (int k = 0; k < 2; k++) chk("R5 desc B data", dev_log[4 + k], exp_elem('h340 + 4 * k, 4));
      for (int k = 0; k < 3; k++) chk("R5 desc C data", dev_log[6 + k], exp_elem('h360 + 2 * k, 2));
      chk("R5 desc reads", 32'(desc_rd), 12);
      chk("R6 chain irqs", 32'(irq_cnt), 2);
      chk("R9 chain act", 32'(act_bad), 0);

      // R7 refused descriptor inside a chain
      put32('h1C0, DEV_A); put32('h1C4, 32'h3A0); put32('h1C8, (32'd3 << 12) | 2); put32('h1CC, 32'h1E2);
      put32('h1E0, DEV_A); put32('h1E4, 32'h3B0); put32('h1E8, (32'd1 << 12) | 2); put32('h1EC, 32'h000);
      reset_run();
      reg_link = 32'h1C0;
      kick();
      wait_idle();
      chk("R7 chain data before error", 32'(dev_n), 2);
      chk("R7 chain err", 32'(err), 1);
      chk("R7 chain irq", 32'(irq_cnt), 1);

      // R8 abort mid transfer
      reset_run();
      cfg_mode = 2'd2; cfg_dir = 1'b1; reg_mem = 32'h200; reg_size = 32'd8; reg_link = 32'h1;
      kick();
      repeat (6) @(negedge clk);
      cfg_mode = 2'd0;
      @(negedge clk);
      chk("R8 abort idle", 32'(act_state), 0);
      repeat (5) @(negedge clk);
      chk("R8 abort no irq", 32'(irq_cnt), 0);
      chk("R8 abort partial", 32'(dev_n < 8), 1);

      // R8 abort in the same cycle as the last write grant
      reset_run();
      abort_idx = 2; abort_arm = 1'b1;
      cfg_mode = 2'd2; reg_size = 32'd3; reg_link = 32'h1;
      kick();
      wait_idle();
      repeat (3) @(negedge clk);
      chk("R8 coincident last write done", 32'(dev_n), 3);
      chk("R8 coincident no irq", 32'(irq_cnt), 0);
      chk("R8 coincident idle", 32'(act_state), 0);
      chk("R8 coincident err low", 32'(err), 0);

      // R11 kick while busy ignored
      reset_run();
      cfg_mode = 2'd2; cfg_dir = 1'b1; reg_mem = 32'h200; reg_size = (32'd3 << 12) | 3; reg_link = 32'h1;
      kick();
      repeat (3) @(negedge clk);
      reg_mem = 32'h280; reg_size = (32'd3 << 12) | 9;
      kick();
      wait_idle();
      chk("R11 count kept", 32'(dev_n), 3);
      chk("R11 data kept", dev_log[2], exp_elem('h202, 1));
      chk("R11 single irq", 32'(irq_cnt), 1);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule